// File: doc/BRIEF.md
# Free-Run / Single-Step Advance Enable

This block produces the per-cycle advance enable for a downstream sequential stage, such as a pseudo-random shift register, that must either run continuously or be stepped by hand. Everything happens on one system clock. The step button is never used as a clock. The raw button level is sampled on that clock, passed through a flip-flop synchronizer, then through a stable-time debouncer, and then reduced to a single-cycle pulse on each rising edge of the cleaned level.

A mode input chooses between the two behaviours. With the mode high, the enable is high on every cycle. With the mode low, only the debounced step pulses get through. A global gate input is ANDed with the result, so the downstream stage holds still whenever the gate is low. The consumer uses the output as a synchronous clock enable on the same clock.

Top module: `step_enable_gen`

## Requirements
- R1: While `run_all` is 1 and `gate_en` is 1, `adv_en` is 1 in every cycle, whatever `step_btn` does.
- R2: While `gate_en` is 0, `adv_en` is 0 in every cycle, in both modes and during presses.
- R3: With `run_all` at 0 and `gate_en` at 1, each clean press gives exactly one cycle of `adv_en` = 1, however long the button stays high. A clean press is one where `step_btn` stays high for at least DEBOUNCE_CYCLES clocks.
- R4: A high level on `step_btn` that lasts fewer than DEBOUNCE_CYCLES consecutive sampled clocks produces no pulse. A button that toggles faster than that also produces none.
- R5: Count rising clock edges starting with the first edge that samples `step_btn` high, and numbering that edge 1. If the button then stays high, the step pulse is visible right after edge SYNC_STAGES+DEBOUNCE_CYCLES and lasts exactly one cycle.
- R6: Releasing the button (a 1-to-0 change of the cleaned level) never produces a pulse.
- R7: `rst` is synchronous and active high. It clears the synchronizer, the debouncer and the edge register. With `run_all` at 0, `adv_en` is 0 during reset and in the first cycle after reset is released.
- R8: Changing `run_all` from 1 to 0 drops `adv_en` in the same cycle. A button that is already held at the switch gives no further pulse until it has been released and pressed again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| run_all | input | 1 | Mode select: 1 advances every cycle, 0 advances on step presses |
| step_btn | input | 1 | Raw push-button level, asynchronous to `clk` |
| gate_en | input | 1 | Global gate ANDed into the output |
| adv_en | output | 1 | One-cycle-wide advance enable for the downstream stage |

## Verification
The assertions assume that `run_all` and `gate_en` are synchronous to `clk`, because they feed the output through logic only. The bench therefore changes them on the falling edge. The assertions also assume that `rst` is held long enough to flush the synchronizer, so the bench keeps reset for several cycles with the button low. The button input is treated as arbitrary. The stimulus drives it in whole-cycle units and uses a small debounce count, so that hold times just below and exactly at the threshold, as well as fast toggling, can be placed on chosen clock edges.

// File: rtl/stepgen_pkg.sv
package stepgen_pkg;

   typedef enum logic {
      MODE_STEP = 1'b0,
      MODE_RUN  = 1'b1
   } adv_mode_e;

   // counter width able to hold values 0 .. n-1, never below one bit
   function automatic int cnt_width(input int n);
      return (n <= 2) ? 1 : $clog2(n);
   endfunction

endpackage

// File: rtl/stepgen_sync.sv
module stepgen_sync #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic d_async,
   output logic d_sync
);

   if (SYNC_STAGES < 2) begin : g_bad_stages
      $error("stepgen_sync: SYNC_STAGES must be at least 2");
   end

   logic [SYNC_STAGES-1:0] chain_q;

   always_ff @(posedge clk) begin
      if (rst) chain_q <= '0;
      else     chain_q <= {chain_q[SYNC_STAGES-2:0], d_async};
   end

   assign d_sync = chain_q[SYNC_STAGES-1];

endmodule

// File: rtl/stepgen_debounce.sv
module stepgen_debounce
   import stepgen_pkg::*;
#(
   parameter int DEBOUNCE_CYCLES = 1_000_000
) (
   input  logic clk,
   input  logic rst,
   input  logic din,
   output logic dout
);

   if (DEBOUNCE_CYCLES < 1) begin : g_bad_count
      $error("stepgen_debounce: DEBOUNCE_CYCLES must be at least 1");
   end

   logic level_q;

   if (DEBOUNCE_CYCLES == 1) begin : g_direct
      // a single agreeing sample is enough: plain register
      always_ff @(posedge clk) begin
         if (rst) level_q <= 1'b0;
         else     level_q <= din;
      end
   end else begin : g_counted
      localparam int CW = cnt_width(DEBOUNCE_CYCLES);
      localparam logic [CW-1:0] LAST = CW'(DEBOUNCE_CYCLES - 1);

      logic [CW-1:0] run_q;

      always_ff @(posedge clk) begin
         if (rst) begin
            run_q   <= '0;
            level_q <= 1'b0;
         end else if (din == level_q) begin
            run_q <= '0;
         end else if (run_q == LAST) begin
            run_q   <= '0;
            level_q <= din;
         end else begin
            run_q <= run_q + 1'b1;
         end
      end

      AST_DB_RANGE: assert property (@(posedge clk) disable iff (rst)
         run_q <= LAST);  // R4

      AST_DB_CAUSE: assert property (@(posedge clk) disable iff (rst)
         !$stable(level_q) |-> $past(din != level_q));  // R4
   end

   assign dout = level_q;

endmodule

// File: rtl/stepgen_edge.sv
module stepgen_edge (
   input  logic clk,
   input  logic rst,
   input  logic level,
   output logic rise
);

   logic prev_q;

   always_ff @(posedge clk) begin
      if (rst) prev_q <= 1'b0;
      else     prev_q <= level;
   end

   assign rise = level & ~prev_q;

   AST_EDGE_SINGLE: assert property (@(posedge clk) disable iff (rst)
      rise |=> !rise);  // R3

endmodule

// File: rtl/step_enable_gen.sv
module step_enable_gen
   import stepgen_pkg::*;
#(
   parameter int SYNC_STAGES     = 2,
   parameter int DEBOUNCE_CYCLES = 1_000_000
) (
   input  logic clk,
   input  logic rst,
   input  logic run_all,
   input  logic step_btn,
   input  logic gate_en,
   output logic adv_en
);

   logic      btn_sync;
   logic      btn_clean;
   logic      step_pulse;
   logic      mode_en;
   adv_mode_e mode;

   stepgen_sync #(
      .SYNC_STAGES(SYNC_STAGES)
   ) u_sync (
      .clk     (clk),
      .rst     (rst),
      .d_async (step_btn),
      .d_sync  (btn_sync)
   );

   stepgen_debounce #(
      .DEBOUNCE_CYCLES(DEBOUNCE_CYCLES)
   ) u_debounce (
      .clk  (clk),
      .rst  (rst),
      .din  (btn_sync),
      .dout (btn_clean)
   );

   stepgen_edge u_edge (
      .clk   (clk),
      .rst   (rst),
      .level (btn_clean),
      .rise  (step_pulse)
   );

   assign mode = run_all ? MODE_RUN : MODE_STEP;

   always_comb begin
      case (mode)
         MODE_RUN: mode_en = 1'b1;
         default:  mode_en = step_pulse;
      endcase
   end

   assign adv_en = mode_en & gate_en;

   AST_GATE_OFF: assert property (@(posedge clk) disable iff (rst)
      !gate_en |-> !adv_en);  // R2

   AST_FREE_RUN: assert property (@(posedge clk) disable iff (rst)
      (run_all && gate_en) |-> adv_en);  // R1

   AST_STEP_ONCE: assert property (@(posedge clk) disable iff (rst)
      (!run_all && adv_en) |=> (run_all || !adv_en));  // R3

   AST_RST_QUIET: assert property (@(posedge clk) disable iff (rst)
      ($fell(rst) && !run_all) |-> !adv_en);  // R7

endmodule

// File: tb/step_enable_gen_tb.sv
`timescale 1ns/1ps
module step_enable_gen_tb;

   localparam int STAGES = 2;
   localparam int DEB    = 4;
   localparam int WIN    = 30;

   logic clk = 1'b0;
   logic rst, run_all, step_btn, gate_en;
   logic adv_en;

   int total = 0;
   int bad   = 0;
   bit done  = 0;

   always #5 clk = ~clk;  // 100 MHz

   step_enable_gen #(
      .SYNC_STAGES     (STAGES),
      .DEBOUNCE_CYCLES (DEB)
   ) u_dut (
      .clk      (clk),
      .rst      (rst),
      .run_all  (run_all),
      .step_btn (step_btn),
      .gate_en  (gate_en),
      .adv_en   (adv_en)
   );

   typedef struct packed {
      logic       run;
      logic       gate;
      logic [7:0] hold;   // cycles the button stays high, 0 = no press
      logic [7:0] pulses; // expected count of adv_en high samples in WIN cycles
   } vec_t;

   localparam int NV = 9;
   localparam vec_t VECS [NV] = '{
      '{1'b1, 1'b1, 8'd0,  8'd30},  // R1 free run, every cycle
      '{1'b1, 1'b0, 8'd0,  8'd0 },  // R2 gate low in free run
      '{1'b0, 1'b1, 8'd10, 8'd1 },  // R3 one press, one pulse; R6 none on release
      '{1'b0, 1'b1, 8'd20, 8'd1 },  // R3 long hold still one pulse
      '{1'b0, 1'b1, 8'd4,  8'd1 },  // R3 hold exactly DEB is accepted
      '{1'b0, 1'b1, 8'd3,  8'd0 },  // R4 hold DEB-1 rejected
      '{1'b0, 1'b0, 8'd10, 8'd0 },  // R2 gate low blocks a press
      '{1'b0, 1'b1, 8'd0,  8'd0 },  // R6 idle, nothing
      '{1'b1, 1'b1, 8'd10, 8'd30}   // R1 button ignored in free run
   };

   task automatic check(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   initial begin
      int cnt;
      rst = 1'b1; run_all = 1'b0; step_btn = 1'b0; gate_en = 1'b1;

      // reset behaviour
      repeat (4) @(negedge clk);
      check(adv_en == 1'b0, "R7 during reset", adv_en, 0);
      rst = 1'b0;
      @(negedge clk);
      check(adv_en == 1'b0, "R7 first cycle after reset", adv_en, 0);
      repeat (3) @(negedge clk);

      // vector table
      for (int v = 0; v < NV; v++) begin
         run_all  = VECS[v].run;
         gate_en  = VECS[v].gate;
         step_btn = (VECS[v].hold != 0);
         cnt = 0;
         for (int c = 0; c < WIN; c++) begin
            @(negedge clk);
            if (adv_en) cnt++;
            if (c + 1 == int'(VECS[v].hold)) step_btn = 1'b0;
         end
         check(cnt == int'(VECS[v].pulses), $sformatf("vector %0d (R1/R2/R3/R4/R6)", v),
               cnt, int'(VECS[v].pulses));
      end

      // R5 exact pulse timing
      run_all = 1'b0; gate_en = 1'b1;
      step_btn = 1'b1;
      for (int k = 1; k <= 8; k++) begin
         @(negedge clk);
         check(adv_en == (k == STAGES + DEB), $sformatf("R5 cycle %0d", k),
               adv_en, (k == STAGES + DEB));
      end
      step_btn = 1'b0;
      repeat (12) @(negedge clk);

      // R4 bouncing button
      cnt = 0;
      for (int t = 0; t < 24; t++) begin
         if (t % 2 == 0) step_btn = ~step_btn;
         @(negedge clk);
         if (adv_en) cnt++;
      end
      step_btn = 1'b0;
      for (int t = 0; t < 12; t++) begin
         @(negedge clk);
         if (adv_en) cnt++;
      end
      check(cnt == 0, "R4 bounce gives no pulse", cnt, 0);

      // R8 mode switch with button held
      step_btn = 1'b1;
      cnt = 0;
      for (int t = 0; t < 10; t++) begin
         @(negedge clk);
         if (adv_en) cnt++;
      end
      check(cnt == 1, "R3 held press before switch", cnt, 1);
      run_all = 1'b1;
      #1;
      check(adv_en == 1'b1, "R1 switch to free run", adv_en, 1);
      @(negedge clk);
      run_all = 1'b0;
      #1;
      check(adv_en == 1'b0, "R8 switch to step drops enable", adv_en, 0);
      cnt = 0;
      for (int t = 0; t < 10; t++) begin
         @(negedge clk);
         if (adv_en) cnt++;
      end
      check(cnt == 0, "R8 no extra pulse while held", cnt, 0);
      step_btn = 1'b0;
      cnt = 0;
      for (int t = 0; t < 12; t++) begin
         @(negedge clk);
         if (adv_en) cnt++;
      end
      check(cnt == 0, "R6 release gives no pulse", cnt, 0);

      // fresh press after release works again
      step_btn = 1'b1;
      cnt = 0;
      for (int t = 0; t < 12; t++) begin
         @(negedge clk);
         if (adv_en) cnt++;
      end
      check(cnt == 1, "R3 press after release", cnt, 1);
      step_btn = 1'b0;
      repeat (10) @(negedge clk);

      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #200000;
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog expired actual=0 expected=1");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule